// File: doc/BRIEF.md
# Paged Host Register Bank for an Ethernet Controller

This block is the byte-wide register interface that a host processor uses to program a legacy Ethernet controller. It decodes a 16-location window. Location 0 always holds the command register. Locations 1 to 15 are remapped by a two-bit page number held in the top two bits of the command register. On page 0 many locations are asymmetric: a write lands in one register and a read at the same location returns a different one.

The bank holds the following configuration and exports it to the rest of the controller:
- receive ring start, stop and boundary pages;
- transmit start page and byte count;
- remote-DMA start address and byte count;
- data configuration;
- six station address bytes, the current receive page and eight multicast mask bytes.

The bank also holds the interrupt status and mask registers and drives one level interrupt line. Status bits are cleared by writing ones. A command write that starts a transmission produces a one-cycle request pulse. The transmit engine answers later with a completion strobe. Packet memory and the movement of frame data live in other blocks.

Top module: `paged_nic_regs`

## Requirements
- R1: Synchronous reset loads the command register with 0x21, the interrupt status with 0x80 and every other register with 0x00. After reset `irq` and `tx_start` are low.
- R2: A read or write at offset 0 reaches the command register whatever the page. For offsets 1 to 15 the register is chosen by {command[7:6], offset}. On page 3 every offset other than 0 reads 0x00 and ignores writes. On page 2, writes at offsets 1 to 15 are ignored.
- R3: On page 0, offsets 1 and 2 write the ring start and stop pages but read bytes 7:0 and 15:8 of `local_dma_addr`. Offset 3 is the ring boundary for both reads and writes. Offset 4 writes the transmit page but reads the transmit status. Offset 14 writes the data configuration. On page 2, offsets 1 and 2 read back the ring start and stop pages.
- R4: A write at page 0 offset 7 clears each status bit in 6:0 whose data bit is 1. Status bit 7 is never changed by such a write. A status bit that is set by an event in the same cycle stays set.
- R5: `irq` is high exactly when (status AND mask) has a nonzero bit among bits 6:0, where the mask is written at page 0 offset 15. Status bit 7 never raises `irq`. `irq` follows a register change from the next cycle.
- R6: A command write with bit 0 clear clears status bit 7. A command write with bit 0 set leaves status bit 7 unchanged.
- R7: A command write with bit 0 clear and bit 3 or bit 4 set, made while the remote byte count is zero, sets status bit 6. When the count is nonzero, status bit 6 is not set.
- R8: A command write with bit 0 clear and bit 2 set makes `tx_start` high for exactly the one cycle after the write. When bit 0 is set, no pulse is produced.
- R9: A `tx_done` strobe sets the transmit status (page 0 offset 4 read) to 0x01, sets status bit 1 and clears command bit 2.
- R10: Page 1 offsets 1 to 6 hold station address bytes 0 to 5, offset 7 holds the current receive page, and offsets 8 to 15 hold multicast mask bytes 0 to 7. All of them can be written and read back. Byte k appears at bits 8k+7:8k of its output.
- R11: The transmit count (page 0 offsets 5 and 6), the remote start address (offsets 8 and 9, readable) and the remote count (offsets 10 and 11) are 16 bits wide. The lower offset holds the low byte. Each byte write replaces only its own half.
- R12: A read at any location that no register decodes returns 0x00. Examples are page 0 offset 5 and page 2 offset 3.
- R13: Each bit of `ext_evt` that is high in a cycle sets the matching status bit 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| addr | input | 4 | Window offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| local_dma_addr | input | 16 | Current local DMA address from the receive engine |
| ext_evt | input | 7 | Event strobes that set status bits 6:0 |
| tx_done | input | 1 | Transmit completion strobe |
| irq | output | 1 | Interrupt request level |
| tx_start | output | 1 | One-cycle transmit request |
| ring_start_o | output | 8 | Receive ring first page |
| ring_stop_o | output | 8 | Receive ring end page |
| boundary_o | output | 8 | Receive ring boundary page |
| tx_page_o | output | 8 | Transmit start page |
| tx_count_o | output | 16 | Transmit byte count |
| rdma_addr_o | output | 16 | Remote-DMA start address |
| rdma_count_o | output | 16 | Remote-DMA byte count |
| data_cfg_o | output | 8 | Data configuration byte |
| cur_page_o | output | 8 | Current receive page |
| station_addr_o | output | 48 | Station address, byte 0 in the low bits |
| mcast_mask_o | output | 64 | Multicast mask, byte 0 in the low bits |

## Verification
The paged decode is exercised by accessing the same offset on pages 0, 1, 2 and 3. This separates the page-0 read/write split, the page-2 readback view and the dead page 3. Interrupt status is driven in three ways: by external events, by clear-writes whose data mixes set and clear bits, and by an event and a clear that land on the same bit in one cycle. This distinguishes the write-one-to-clear path from the set path and shows that bit 7 cannot be cleared by a status write. Command writes are applied with the stop bit both set and clear, with the remote count both zero and nonzero, and with the transmit bit on and off. This separates the reset-flag clear, the zero-count completion and the transmit pulse from one another.

// File: rtl/pnr_pkg.sv
package pnr_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int OFS_W      = 4;
    localparam int PAGE_W     = 2;
    localparam int SEL_W      = PAGE_W + OFS_W;
    localparam int EVT_W      = BYTE_W - 1;
    localparam int STN_BYTES  = 6;
    localparam int HASH_BYTES = 8;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // command bit positions
    localparam int CB_STOP   = 0;
    localparam int CB_XMIT   = 2;
    localparam int CB_RREAD  = 3;
    localparam int CB_RWRITE = 4;

    // status bit positions
    localparam int IS_TX_OK     = 1;
    localparam int IS_RDMA_DONE = 6;
    localparam int IS_RESET     = 7;

    localparam byte_t CMD_RESET = 8'h21;
    localparam byte_t ISR_RESET = 8'h80;
    localparam byte_t TSR_SENT  = 8'h01;

    // {page, offset} selectors
    localparam sel_t S_RING_A  = 6'h01;
    localparam sel_t S_RING_B  = 6'h02;
    localparam sel_t S_BOUND   = 6'h03;
    localparam sel_t S_TXPG    = 6'h04;
    localparam sel_t S_TCNT_L  = 6'h05;
    localparam sel_t S_TCNT_H  = 6'h06;
    localparam sel_t S_STAT    = 6'h07;
    localparam sel_t S_RSA_L   = 6'h08;
    localparam sel_t S_RSA_H   = 6'h09;
    localparam sel_t S_RCNT_L  = 6'h0A;
    localparam sel_t S_RCNT_H  = 6'h0B;
    localparam sel_t S_DCFG    = 6'h0E;
    localparam sel_t S_MASK    = 6'h0F;
    localparam sel_t S_STN0    = 6'h11;
    localparam sel_t S_CURPG   = 6'h17;
    localparam sel_t S_HASH0   = 6'h18;
    localparam sel_t S_RB_A    = 6'h21;
    localparam sel_t S_RB_B    = 6'h22;

    typedef struct packed {
        logic cmd_wr;
        logic reg_wr;
        sel_t sel;
    } bus_dec_t;

    function automatic sel_t make_sel(input logic [PAGE_W-1:0] page,
                                      input logic [OFS_W-1:0] ofs);
        return {page, ofs};
    endfunction

    function automatic word_t put_byte(input word_t w, input logic hi, input byte_t b);
        return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
    endfunction
endpackage

// File: rtl/nrf_decode.sv
module nrf_decode import pnr_pkg::*; (
    input  byte_t              cmd,
    input  logic               wr_en,
    input  logic [OFS_W-1:0]   addr,
    output bus_dec_t           dec
);
    logic at_cmd;
    assign at_cmd     = (addr == '0);
    assign dec.cmd_wr = wr_en && at_cmd;
    assign dec.reg_wr = wr_en && !at_cmd;
    assign dec.sel    = make_sel(cmd[BYTE_W-1 -: PAGE_W], addr);
endmodule

// File: rtl/nrf_intr.sv
module nrf_intr import pnr_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_wr,
    input  logic [EVT_W-1:0] clr_bits,
    input  logic             mask_wr,
    input  byte_t            mask_val,
    input  logic [EVT_W-1:0] set_bits,
    input  logic             reset_flag_clr,
    output byte_t            status,
    output byte_t            mask,
    output logic             irq
);
    logic [EVT_W-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= ISR_RESET;
            mask   <= '0;
        end else begin
            if (mask_wr) mask <= mask_val;
            if (reset_flag_clr) status[IS_RESET] <= 1'b0;
            // a set arriving with a clear on the same bit wins
            status[EVT_W-1:0] <= (status[EVT_W-1:0] & ~clr_eff) | set_bits;
        end
    end

    assign irq = |(status[EVT_W-1:0] & mask[EVT_W-1:0]);
endmodule

// File: rtl/nrf_station.sv
module nrf_station import pnr_pkg::*; #(
    parameter int N_STN  = STN_BYTES,
    parameter int N_HASH = HASH_BYTES
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  sel_t                     sel,
    input  byte_t                    wdata,
    output logic [N_STN*BYTE_W-1:0]  stn,
    output logic [N_HASH*BYTE_W-1:0] hash,
    output logic                     rd_hit,
    output byte_t                    rd_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stn  <= '0;
            hash <= '0;
        end else if (wr) begin
            for (int i = 0; i < N_STN; i++)
                if (sel == sel_t'(S_STN0 + i)) stn[i*BYTE_W +: BYTE_W] <= wdata;
            for (int j = 0; j < N_HASH; j++)
                if (sel == sel_t'(S_HASH0 + j)) hash[j*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    always_comb begin
        rd_hit = 1'b0;
        rd_val = '0;
        for (int i = 0; i < N_STN; i++)
            if (sel == sel_t'(S_STN0 + i)) begin
                rd_hit = 1'b1;
                rd_val = stn[i*BYTE_W +: BYTE_W];
            end
        for (int j = 0; j < N_HASH; j++)
            if (sel == sel_t'(S_HASH0 + j)) begin
                rd_hit = 1'b1;
                rd_val = hash[j*BYTE_W +: BYTE_W];
            end
    end
endmodule

// File: rtl/paged_nic_regs.sv
module paged_nic_regs import pnr_pkg::*; (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [OFS_W-1:0]             addr,
    input  logic [BYTE_W-1:0]            wdata,
    output logic [BYTE_W-1:0]            rdata,
    input  logic [WORD_W-1:0]            local_dma_addr,
    input  logic [EVT_W-1:0]             ext_evt,
    input  logic                         tx_done,
    output logic                         irq,
    output logic                         tx_start,
    output logic [BYTE_W-1:0]            ring_start_o,
    output logic [BYTE_W-1:0]            ring_stop_o,
    output logic [BYTE_W-1:0]            boundary_o,
    output logic [BYTE_W-1:0]            tx_page_o,
    output logic [WORD_W-1:0]            tx_count_o,
    output logic [WORD_W-1:0]            rdma_addr_o,
    output logic [WORD_W-1:0]            rdma_count_o,
    output logic [BYTE_W-1:0]            data_cfg_o,
    output logic [BYTE_W-1:0]            cur_page_o,
    output logic [STN_BYTES*BYTE_W-1:0]  station_addr_o,
    output logic [HASH_BYTES*BYTE_W-1:0] mcast_mask_o
);
    byte_t    cmd_q, ring_start_q, ring_stop_q, boundary_q, tx_page_q, tsr_q;
    byte_t    dcfg_q, curpg_q, isr_w, imr_w, stn_val;
    word_t    tx_cnt_q, rsa_q, rcnt_q;
    logic     tx_start_q, live_cmd, rdma_zero, stn_hit;
    logic [EVT_W-1:0] set_vec;
    bus_dec_t dec;

    nrf_decode u_dec (
        .cmd(cmd_q), .wr_en(wr_en), .addr(addr), .dec(dec)
    );

    assign live_cmd  = dec.cmd_wr && !wdata[CB_STOP];
    assign rdma_zero = live_cmd && (wdata[CB_RREAD] || wdata[CB_RWRITE]) && (rcnt_q == '0);

    always_comb begin
        set_vec = ext_evt;
        if (tx_done)   set_vec[IS_TX_OK]     = 1'b1;
        if (rdma_zero) set_vec[IS_RDMA_DONE] = 1'b1;
    end

    nrf_intr u_intr (
        .clk(clk), .rst(rst),
        .clr_wr(dec.reg_wr && dec.sel == S_STAT), .clr_bits(wdata[EVT_W-1:0]),
        .mask_wr(dec.reg_wr && dec.sel == S_MASK), .mask_val(wdata),
        .set_bits(set_vec), .reset_flag_clr(live_cmd),
        .status(isr_w), .mask(imr_w), .irq(irq)
    );

    nrf_station #(.N_STN(STN_BYTES), .N_HASH(HASH_BYTES)) u_stn (
        .clk(clk), .rst(rst), .wr(dec.reg_wr), .sel(dec.sel), .wdata(wdata),
        .stn(station_addr_o), .hash(mcast_mask_o), .rd_hit(stn_hit), .rd_val(stn_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q        <= CMD_RESET;
            ring_start_q <= '0;
            ring_stop_q  <= '0;
            boundary_q   <= '0;
            tx_page_q    <= '0;
            tsr_q        <= '0;
            tx_cnt_q     <= '0;
            rsa_q        <= '0;
            rcnt_q       <= '0;
            dcfg_q       <= '0;
            curpg_q      <= '0;
            tx_start_q   <= 1'b0;
        end else begin
            tx_start_q <= live_cmd && wdata[CB_XMIT];
            if (dec.cmd_wr)   cmd_q <= wdata;
            else if (tx_done) cmd_q[CB_XMIT] <= 1'b0;
            if (tx_done) tsr_q <= TSR_SENT;
            if (dec.reg_wr) begin
                case (dec.sel)
                    S_RING_A: ring_start_q <= wdata;
                    S_RING_B: ring_stop_q  <= wdata;
                    S_BOUND:  boundary_q   <= wdata;
                    S_TXPG:   tx_page_q    <= wdata;
                    S_TCNT_L: tx_cnt_q     <= put_byte(tx_cnt_q, 1'b0, wdata);
                    S_TCNT_H: tx_cnt_q     <= put_byte(tx_cnt_q, 1'b1, wdata);
                    S_RSA_L:  rsa_q        <= put_byte(rsa_q, 1'b0, wdata);
                    S_RSA_H:  rsa_q        <= put_byte(rsa_q, 1'b1, wdata);
                    S_RCNT_L: rcnt_q       <= put_byte(rcnt_q, 1'b0, wdata);
                    S_RCNT_H: rcnt_q       <= put_byte(rcnt_q, 1'b1, wdata);
                    S_DCFG:   dcfg_q       <= wdata;
                    S_CURPG:  curpg_q      <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == '0)   rdata = cmd_q;
        else if (stn_hit) rdata = stn_val;
        else begin
            case (dec.sel)
                S_RING_A: rdata = local_dma_addr[BYTE_W-1:0];
                S_RING_B: rdata = local_dma_addr[WORD_W-1:BYTE_W];
                S_BOUND:  rdata = boundary_q;
                S_TXPG:   rdata = tsr_q;
                S_STAT:   rdata = isr_w;
                S_RSA_L:  rdata = rsa_q[BYTE_W-1:0];
                S_RSA_H:  rdata = rsa_q[WORD_W-1:BYTE_W];
                S_CURPG:  rdata = curpg_q;
                S_RB_A:   rdata = ring_start_q;
                S_RB_B:   rdata = ring_stop_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign tx_start     = tx_start_q;
    assign ring_start_o = ring_start_q;
    assign ring_stop_o  = ring_stop_q;
    assign boundary_o   = boundary_q;
    assign tx_page_o    = tx_page_q;
    assign tx_count_o   = tx_cnt_q;
    assign rdma_addr_o  = rsa_q;
    assign rdma_count_o = rcnt_q;
    assign data_cfg_o   = dcfg_q;
    assign cur_page_o   = curpg_q;
endmodule

// File: rtl/nrf_checks.sv
module nrf_checks import pnr_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [OFS_W-1:0] addr,
    input byte_t            wdata,
    input logic             tx_done,
    input logic             irq,
    input logic             tx_start,
    input byte_t            status,
    input byte_t            mask,
    input byte_t            cmd,
    input word_t            rcnt
);
    // R1
    a_r1_status_after_reset: assert property (@(posedge clk)
        rst |=> (status == ISR_RESET));

    // R6: reset flag only drops after a running command write
    a_r6_flag_fall_source: assert property (@(posedge clk) disable iff (rst)
        $fell(status[IS_RESET]) |-> $past(wr_en && addr == '0 && !wdata[CB_STOP]));

    // R4: a status write never clears bit 7
    a_r4_flag_survives_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd7 && cmd[7:6] == 2'd0 && status[IS_RESET]) |=> status[IS_RESET]);

    // R7
    a_r7_zero_count_done: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0 && !wdata[CB_STOP] && (wdata[CB_RREAD] || wdata[CB_RWRITE])
         && rcnt == '0) |=> status[IS_RDMA_DONE]);

    // R8
    a_r8_pulse_source: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(wr_en && addr == '0 && !wdata[CB_STOP] && wdata[CB_XMIT]));

    // R9
    a_r9_done_effects: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !(wr_en && addr == '0)) |=> (!cmd[CB_XMIT] && status[IS_TX_OK]));

    // R5
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask[EVT_W-1:0] == '0) |-> !irq);
    a_r5_flag_never_raises: assert property (@(posedge clk) disable iff (rst)
        (status[EVT_W-1:0] == '0) |-> !irq);
endmodule

bind paged_nic_regs nrf_checks u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tx_done(tx_done), .irq(irq), .tx_start(tx_start),
    .status(isr_w), .mask(imr_w), .cmd(cmd_q), .rcnt(rcnt_q)
);

// File: tb/paged_nic_regs_tb_top.sv
module paged_nic_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] local_dma_addr = 16'hBEEF;
    logic [6:0]  ext_evt = '0;
    logic        tx_done = 1'b0;
    logic        irq, tx_start;
    logic [7:0]  ring_start_o, ring_stop_o, boundary_o, tx_page_o, data_cfg_o, cur_page_o;
    logic [15:0] tx_count_o, rdma_addr_o, rdma_count_o;
    logic [47:0] station_addr_o;
    logic [63:0] mcast_mask_o;

    always #5 clk = ~clk;

    paged_nic_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .local_dma_addr(local_dma_addr), .ext_evt(ext_evt), .tx_done(tx_done),
        .irq(irq), .tx_start(tx_start), .ring_start_o(ring_start_o),
        .ring_stop_o(ring_stop_o), .boundary_o(boundary_o), .tx_page_o(tx_page_o),
        .tx_count_o(tx_count_o), .rdma_addr_o(rdma_addr_o), .rdma_count_o(rdma_count_o),
        .data_cfg_o(data_cfg_o), .cur_page_o(cur_page_o),
        .station_addr_o(station_addr_o), .mcast_mask_o(mcast_mask_o)
    );

    localparam int K_RD = 0, K_IRQ = 1, K_TXS = 2, K_TCNT = 3, K_RSA = 4, K_RCNT = 5;
    localparam int K_RSTART = 6, K_DCFG = 7, K_CURPG = 8, K_STN = 9, K_TXPG = 10, K_HASH = 11;

    typedef struct {
        int          kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [63:0] got_of(int k);
        case (k)
            K_RD:     return {56'd0, rdata};
            K_IRQ:    return {63'd0, irq};
            K_TXS:    return {63'd0, tx_start};
            K_TCNT:   return {48'd0, tx_count_o};
            K_RSA:    return {48'd0, rdma_addr_o};
            K_RCNT:   return {48'd0, rdma_count_o};
            K_RSTART: return {56'd0, ring_start_o};
            K_DCFG:   return {56'd0, data_cfg_o};
            K_CURPG:  return {56'd0, cur_page_o};
            K_STN:    return {16'd0, station_addr_o};
            K_TXPG:   return {56'd0, tx_page_o};
            default:  return mcast_mask_o;
        endcase
    endfunction

    // monitor: compares everything queued for the current cycle
    initial begin
        item_t it;
        logic [63:0] got;
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                it  = q.pop_front();
                got = got_of(it.kind);
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
                end
            end
        end
    end

    task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                       input logic [6:0] ev = '0, input logic td = 1'b0);
        @(negedge clk);
        wr_en = w; addr = a; wdata = d; ext_evt = ev; tx_done = td;
    endtask

    task automatic chk(input int k, input logic [63:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string r);
        cyc(1'b0, a, 8'h00);
        chk(K_RD, {56'd0, e}, r);
    endtask

    task automatic idle();
        cyc(1'b0, 4'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, 8'h21, "R1 cmd");
        chk(K_IRQ, 0, "R1 irq");
        chk(K_TXS, 0, "R1 tx_start");
        rd(4'd7, 8'h80, "R1 status");
        rd(4'd3, 8'h00, "R1 boundary");
        chk(K_TCNT, 0, "R1 tx count");

        // R4/R5: bit 7 immune to clear-write and never raises irq
        wr(4'd15, 8'hFF);
        wr(4'd7, 8'hFF);
        rd(4'd7, 8'h80, "R4 bit7 kept");
        chk(K_IRQ, 0, "R5 bit7 no irq");

        // R6
        wr(4'd0, 8'h21);
        rd(4'd7, 8'h80, "R6 stop write keeps flag");
        wr(4'd0, 8'h22);
        rd(4'd7, 8'h00, "R6 run write clears flag");

        // R13 / R4 / R5
        cyc(1'b0, 4'd0, 8'h00, 7'h35);
        rd(4'd7, 8'h35, "R13 events set");
        chk(K_IRQ, 1, "R5 irq high");
        cyc(1'b1, 4'd7, 8'h01, 7'h01);
        rd(4'd7, 8'h35, "R4 set beats clear");
        wr(4'd7, 8'h05);
        rd(4'd7, 8'h30, "R4 selective clear");
        wr(4'd15, 8'h00);
        idle(); chk(K_IRQ, 0, "R5 mask all");
        wr(4'd15, 8'h10);
        idle(); chk(K_IRQ, 1, "R5 mask bit4");
        wr(4'd7, 8'h10);
        idle(); chk(K_IRQ, 0, "R5 cleared source");
        wr(4'd7, 8'h7F);

        // R11
        wr(4'd5, 8'h34); wr(4'd6, 8'h12);
        idle(); chk(K_TCNT, 64'h1234, "R11 tx count");
        wr(4'd5, 8'hAB);
        idle(); chk(K_TCNT, 64'h12AB, "R11 low half only");
        wr(4'd8, 8'h00); wr(4'd9, 8'h40);
        rd(4'd8, 8'h00, "R11 rsa lo");
        rd(4'd9, 8'h40, "R11 rsa hi");
        chk(K_RSA, 64'h4000, "R11 rsa out");

        // R7
        wr(4'd0, 8'h0A);
        rd(4'd7, 8'h40, "R7 zero count done");
        wr(4'd7, 8'h7F);
        wr(4'd10, 8'h10);
        wr(4'd0, 8'h12);
        rd(4'd7, 8'h00, "R7 nonzero count");
        chk(K_RCNT, 64'h0010, "R11 rcount lo");
        wr(4'd11, 8'h02);
        idle(); chk(K_RCNT, 64'h0210, "R11 rcount hi");

        // R8 / R9
        wr(4'd0, 8'h26);
        idle(); chk(K_TXS, 1, "R8 pulse");
        rd(4'd0, 8'h26, "R8 cmd value"); chk(K_TXS, 0, "R8 one cycle");
        cyc(1'b0, 4'd0, 8'h00, 7'h00, 1'b1);
        rd(4'd4, 8'h01, "R9 tx status");
        rd(4'd0, 8'h22, "R9 xmit bit cleared");
        rd(4'd7, 8'h02, "R9 tx ok");
        chk(K_IRQ, 0, "R5 masked tx ok");
        wr(4'd15, 8'h02);
        idle(); chk(K_IRQ, 1, "R5 tx irq");
        wr(4'd7, 8'h02);
        wr(4'd0, 8'h25);
        idle(); chk(K_TXS, 0, "R8 no pulse when stopped");
        wr(4'd0, 8'h22);

        // R3
        wr(4'd1, 8'h46); wr(4'd2, 8'h80); wr(4'd4, 8'h40); wr(4'd14, 8'h49); wr(4'd3, 8'h5A);
        rd(4'd1, 8'hEF, "R3 local addr lo");
        chk(K_RSTART, 64'h46, "R3 ring start out");
        rd(4'd2, 8'hBE, "R3 local addr hi");
        rd(4'd4, 8'h01, "R3 tsr view");
        chk(K_TXPG, 64'h40, "R3 tx page out");
        chk(K_DCFG, 64'h49, "R3 dcfg out");
        rd(4'd3, 8'h5A, "R3 boundary");
        rd(4'd5, 8'h00, "R12 p0 ofs5");
        wr(4'd0, 8'hA2);
        rd(4'd1, 8'h46, "R3 p2 start");
        rd(4'd2, 8'h80, "R3 p2 stop");
        rd(4'd3, 8'h00, "R12 p2 ofs3");
        wr(4'd1, 8'h99);
        idle(); chk(K_RSTART, 64'h46, "R2 p2 write ignored");

        // R10
        wr(4'd0, 8'h62);
        for (int i = 1; i <= 6; i++) wr(4'(i), 8'(8'h10 + i));
        wr(4'd7, 8'h4C);
        for (int i = 8; i <= 15; i++) wr(4'(i), 8'(8'hA0 + i));
        for (int i = 1; i <= 6; i++) rd(4'(i), 8'(8'h10 + i), "R10 station");
        rd(4'd7, 8'h4C, "R10 cur page");
        chk(K_CURPG, 64'h4C, "R10 cur page out");
        rd(4'd8, 8'hA8, "R10 mask0");
        rd(4'd15, 8'hAF, "R10 mask7");
        chk(K_STN, 64'h0000_1615_1413_1211, "R10 station out");
        chk(K_HASH, 64'hAFAE_ADAC_ABAA_A9A8, "R10 mask out");

        // R2 page 3
        wr(4'd0, 8'hE2);
        rd(4'd0, 8'hE2, "R2 cmd any page");
        rd(4'd5, 8'h00, "R2 p3 reads zero");
        rd(4'd1, 8'h00, "R2 p3 ofs1");

        idle(); idle();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule